// File: doc/BRIEF.md
# Watch Timer with Programmable Period

This block is a real-time watch timer for a small 8-bit microcontroller. One of four tick inputs, each a single-cycle enable pulse in the system clock domain, is picked by a control field. Each selected tick advances a 14-bit prescaler. Every full turn of the prescaler advances a 7-bit counter. The counter runs from zero up to a programmable period value and then wraps. The wrap, or one of three fixed prescaler taps, sets an interrupt flag. The interrupt request output follows that flag.

Software reaches the block through a simple byte-wide register bus. The bus has a combinational read path and a single-cycle write strobe. The counter and period registers share one address and are told apart by the access direction. Reads return the live counter. Writes load the period, and the top bit of a write is a one-shot counter-clear request. A second address holds the control register. It carries the enable, the tick-source select, the interval select and the interrupt flag.

Top module: `wt_watch_timer`

## Requirements
- R1: After reset the counter reads 0x00, the control register reads 0x00, `irq` is low and the period register holds 0x7F.
- R2: A read of address 0x89 returns the live counter in bits [6:0] with bit 7 as 0. The counter advances once per 2^14 selected ticks, on the tick that turns the prescaler over.
- R3: A write to 0x89 loads bits [6:0] into the period register. With interval select 3, the counter wraps to 0 on the step after it equals the period. The flag is set on that same edge, so the interval is 2^14 × (period + 1) ticks.
- R4: A write to 0x89 with bit 7 set forces the counter to 0 on that write's edge, and the prescaler is left undisturbed. The bit is never stored: it reads back as 0, and counting resumes at the next prescaler turn.
- R5: A period value of 0 behaves exactly like a period of 1.
- R6: The control register at 0x8F has this layout: bit 7 is the enable, bits [5:4] the tick-source select, bits [3:2] the interval select and bit 0 the interrupt flag. Bits 6 and 1 read as 0.
- R7: The interrupt flag is set by hardware on the selected interval event. A control write with bit 0 = 0 clears it, and a control write with bit 0 = 1 leaves it unchanged. When a set and a clear fall on the same edge, the set wins.
- R8: Interval select picks the event source. Code 0 fires every 2^7 ticks, code 1 every 2^13 ticks, code 2 every 2^14 ticks, and code 3 on the counter match.
- R9: While the enable is 0, the prescaler and the counter are held at 0 and the flag cannot be set.
- R10: Only the tick input numbered by the tick-source select advances the prescaler. The other three inputs have no effect.
- R11: `irq` is high exactly while the interrupt flag is set.
- R12: Reads of any other address return 0, and writes to any other address change no register.

Every tick inputs are listed with the port table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | 4 | Four candidate watch-clock tick pulses |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt request, high while the flag is set |

## Verification
The assertions check the following on every cycle:
- the period reset value;
- that a clear request zeroes the counter;
- that a match wraps the counter;
- that the counter moves only on a step, a clear or while disabled;
- that the disabled state holds the prescaler and the counter at zero;
- that an interval event always leaves the flag raised.

The bench scenarios cover the exact tick counts behind each interval code and the treatment of a zero period. They also cover the priority of a set over a same-edge clear, the independence of the tick inputs and the non-stored clear bit. Each of these depends on a long run of ticks or on precise write timing, which only a directed sequence can show.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int WT_BUS_W = 8;

  typedef enum logic [1:0] {
    IV_TAP_LO  = 2'd0,
    IV_TAP_MID = 2'd1,
    IV_TAP_TOP = 2'd2,
    IV_MATCH   = 2'd3
  } wt_isel_e;

  typedef struct packed {
    logic     en;
    logic     rsv6;
    logic [1:0] csel;
    wt_isel_e isel;
    logic     rsv1;
    logic     flag;
  } wt_ctrl_t;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int PRE_W   = 14,
  parameter int TAP_LO  = 7,
  parameter int TAP_MID = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  output logic [PRE_W-1:0] pre_q,
  output logic             tap_lo,
  output logic             tap_mid,
  output logic             tap_top
);
  function automatic logic low_ones(input logic [PRE_W-1:0] v, input int n);
    logic [PRE_W-1:0] m;
    m = (PRE_W'(1) << n) - PRE_W'(1);
    return (v & m) == m;
  endfunction

  logic adv;
  assign adv     = en & tick;
  assign tap_lo  = adv & low_ones(pre_q, TAP_LO);
  assign tap_mid = adv & low_ones(pre_q, TAP_MID);
  assign tap_top = adv & low_ones(pre_q, PRE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (!en) pre_q <= '0;
    else if (adv) pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic             clr,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match
);
  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] p);
    return (p == '0) ? CNT_W'(1) : p;
  endfunction

  assign match = step & (cnt_q == eff_period(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en || clr) cnt_q <= '0;
    else if (match)      cnt_q <= '0;
    else if (step)       cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int                 CNT_W      = 7,
  parameter int                 AW         = 8,
  parameter logic [AW-1:0]      CNT_ADDR   = 8'h89,
  parameter logic [AW-1:0]      CTRL_ADDR  = 8'h8F,
  parameter logic [CNT_W-1:0]   PERIOD_RST = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [WT_BUS_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]    cnt_q,
  input  logic                set_evt,
  output logic [CNT_W-1:0]    period_q,
  output wt_ctrl_t            ctrl_q,
  output logic                clr,
  output logic [WT_BUS_W-1:0] bus_rdata
);
  localparam int PAD_W = WT_BUS_W - CNT_W;

  logic wr_cnt, wr_ctrl;
  assign wr_cnt  = bus_wr && (bus_addr == CNT_ADDR);
  assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
  assign clr     = wr_cnt && bus_wdata[WT_BUS_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PERIOD_RST;
      ctrl_q   <= '0;
    end else begin
      if (wr_cnt) period_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctrl) begin
        ctrl_q.en   <= bus_wdata[7];
        ctrl_q.csel <= bus_wdata[5:4];
        ctrl_q.isel <= wt_isel_e'(bus_wdata[3:2]);
      end
      if (set_evt)                      ctrl_q.flag <= 1'b1;
      else if (wr_ctrl && !bus_wdata[0]) ctrl_q.flag <= 1'b0;
    end
  end

  always_comb begin
    if (bus_addr == CNT_ADDR)       bus_rdata = {{PAD_W{1'b0}}, cnt_q};
    else if (bus_addr == CTRL_ADDR) bus_rdata = {ctrl_q.en, 1'b0, ctrl_q.csel, ctrl_q.isel, 1'b0, ctrl_q.flag};
    else                            bus_rdata = '0;
  end
endmodule

// File: rtl/wt_watch_timer.sv
module wt_watch_timer
  import wt_pkg::*;
#(
  parameter int            PRE_W     = 14,
  parameter int            CNT_W     = 7,
  parameter int            TAP_LO    = 7,
  parameter int            TAP_MID   = 13,
  parameter int            AW        = 8,
  parameter logic [AW-1:0] CNT_ADDR  = 8'h89,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h8F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          tick_src,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [WT_BUS_W-1:0] bus_wdata,
  output logic [WT_BUS_W-1:0] bus_rdata,
  output logic                irq
);
  wt_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] period_q, cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic tick, tap_lo, tap_mid, tap_top, match, clr, evt, set_evt;

  assign tick = tick_src[ctrl_q.csel];

  wt_prescaler #(.PRE_W(PRE_W), .TAP_LO(TAP_LO), .TAP_MID(TAP_MID)) pre_i (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .tick(tick), .pre_q(pre_q),
    .tap_lo(tap_lo), .tap_mid(tap_mid), .tap_top(tap_top));

  wt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .step(tap_top), .clr(clr),
    .period(period_q), .cnt_q(cnt_q), .match(match));

  always_comb begin
    unique case (ctrl_q.isel)
      IV_TAP_LO:  evt = tap_lo;
      IV_TAP_MID: evt = tap_mid;
      IV_TAP_TOP: evt = tap_top;
      default:    evt = match;
    endcase
  end
  assign set_evt = ctrl_q.en & evt;

  wt_regs #(.CNT_W(CNT_W), .AW(AW), .CNT_ADDR(CNT_ADDR), .CTRL_ADDR(CTRL_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_q(cnt_q), .set_evt(set_evt), .period_q(period_q), .ctrl_q(ctrl_q),
    .clr(clr), .bus_rdata(bus_rdata));

  assign irq = ctrl_q.flag;
endmodule

// File: rtl/wt_watch_timer_checker.sv
module wt_watch_timer_checker #(
  parameter int            PRE_W    = 14,
  parameter int            CNT_W    = 7,
  parameter int            AW       = 8,
  parameter logic [AW-1:0] CNT_ADDR = 8'h89
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic             irq,
  input logic             en,
  input logic [CNT_W-1:0] period_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             step,
  input logic             match,
  input logic             clr,
  input logic             set_evt
);
  assert_period_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (period_q == '1));

  assert_cnt_bit7_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CNT_ADDR) |-> !bus_rdata[7]);

  assert_cnt_moves_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $past(step || clr || !en));

  assert_match_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == '0));

  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CNT_ADDR && bus_wdata[7]) |=> (cnt_q == '0));

  assert_event_raises_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq);

  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pre_q == '0 && cnt_q == '0));

  assert_no_event_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !set_evt);
endmodule

bind wt_watch_timer wt_watch_timer_checker #(
  .PRE_W(PRE_W), .CNT_W(CNT_W), .AW(AW), .CNT_ADDR(CNT_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .en(ctrl_q.en),
  .period_q(period_q), .pre_q(pre_q), .cnt_q(cnt_q), .step(tap_top),
  .match(match), .clr(clr), .set_evt(set_evt)
);

// File: tb/wt_watch_timer_tb_top.sv
`timescale 1ns/1ps
module wt_watch_timer_tb_top;
  localparam logic [7:0] A_CNT  = 8'h89;
  localparam logic [7:0] A_CTRL = 8'h8F;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick1 = 1'b0;
  logic [3:0] tick_src;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // source 0 always ticks, 1 ticks every other cycle, 2 never, 3 always
  assign tick_src = {1'b1, 1'b0, tick1, 1'b1};

  always #4 clk = ~clk;
  always @(negedge clk) tick1 <= ~tick1;

  wt_watch_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 8'h00;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_read(A_CNT, d);  chk("R1 counter", d, 8'h00);
    bus_read(A_CTRL, d); chk("R1 control", d, 8'h00);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_ctrl_layout;
    logic [7:0] d;
    bus_write(A_CTRL, 8'h7E);
    bus_read(A_CTRL, d); chk("R6 reserved bits read 0", d, 8'h3C);
    bus_write(A_CTRL, 8'h00);
    bus_read(A_CTRL, d); chk("R6 cleared", d, 8'h00);
  endtask

  task automatic t_other_addr;
    logic [7:0] d;
    bus_write(8'h8A, 8'hFF);
    bus_read(A_CTRL, d); chk("R12 ctrl untouched", d, 8'h00);
    bus_read(8'h8A, d);  chk("R12 unmapped read", d, 8'h00);
    chk("R12 irq", irq, 1'b0);
  endtask

  task automatic t_tap_lo_and_flag;
    wait_cyc(300);
    chk("R9 no irq while off", irq, 1'b0);
    bus_write(A_CTRL, 8'h80);
    wait_cyc(127);
    chk("R8 code0 before 2^7", irq, 1'b0);
    chk("R9 prescaler was held at 0", irq, 1'b0);
    bus_write(A_CTRL, 8'h80);
    chk("R7 set wins over same-edge clear", irq, 1'b1);
    bus_write(A_CTRL, 8'h81);
    chk("R7 writing 1 keeps flag", irq, 1'b1);
    bus_write(A_CTRL, 8'h80);
    chk("R11 irq drops with flag", irq, 1'b0);
    bus_write(A_CTRL, 8'h00);
  endtask

  task automatic t_tap(input logic [7:0] ctl, input int n, input string req);
    bus_write(A_CTRL, ctl);
    wait_cyc(n - 1);
    chk({req, " before"}, irq, 1'b0);
    wait_cyc(1);
    chk({req, " at interval"}, irq, 1'b1);
    bus_write(A_CTRL, 8'h00);
  endtask

  task automatic t_csel;
    bus_write(A_CTRL, 8'hA0);
    wait_cyc(300);
    chk("R10 silent source gives no event", irq, 1'b0);
    bus_write(A_CTRL, 8'h90);
    wait_cyc(250);
    chk("R10 half-rate source not yet", irq, 1'b0);
    wait_cyc(10);
    chk("R10 half-rate source fired", irq, 1'b1);
    bus_write(A_CTRL, 8'h00);
  endtask

  task automatic t_match_and_clear;
    logic [7:0] d;
    bus_write(A_CNT, 8'h01);
    bus_write(A_CTRL, 8'h8C);
    wait_cyc(16383);
    bus_read(A_CNT, d); chk("R2 counter before turn", d, 8'h00);
    wait_cyc(1);
    bus_read(A_CNT, d); chk("R2 counter steps", d, 8'h01);
    wait_cyc(16383);
    chk("R3 no irq before match", irq, 1'b0);
    wait_cyc(1);
    chk("R3 irq at 2^14*(P+1)", irq, 1'b1);
    bus_read(A_CNT, d); chk("R3 counter wrapped", d, 8'h00);
    wait_cyc(16384);
    bus_read(A_CNT, d); chk("R2 counter steps again", d, 8'h01);
    bus_write(A_CNT, 8'h81);
    bus_read(A_CNT, d); chk("R4 clear zeroes counter", d, 8'h00);
    chk("R4 bit7 reads 0", d[7], 1'b0);
    wait_cyc(16382);
    bus_read(A_CNT, d); chk("R4 counter stays cleared", d, 8'h00);
    wait_cyc(1);
    bus_read(A_CNT, d); chk("R4 counting resumes, prescaler kept", d, 8'h01);
    bus_write(A_CTRL, 8'h00);
  endtask

  task automatic t_period_zero;
    logic [7:0] d;
    bus_write(A_CNT, 8'h00);
    bus_write(A_CTRL, 8'h8C);
    wait_cyc(16384);
    chk("R5 no match at count 0", irq, 1'b0);
    bus_read(A_CNT, d); chk("R5 counter reaches 1", d, 8'h01);
    wait_cyc(16383);
    chk("R5 not yet", irq, 1'b0);
    wait_cyc(1);
    chk("R5 zero acts as one", irq, 1'b1);
    bus_write(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_layout();
    t_other_addr();
    t_tap_lo_and_flag();
    t_tap(8'h84, 8192,  "R8 code1 2^13");
    t_tap(8'h88, 16384, "R8 code2 2^14");
    t_csel();
    t_match_and_clear();
    t_period_zero();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule